// File: doc/BRIEF.md
# Configuration Image Sync Finder

This block sits on the byte stream that carries a configuration image towards a device loader. The image opens with a descriptive header that the loader does not want. The payload starts at a synchronisation pattern. The block drops everything ahead of that pattern and forwards only the payload bytes, marking the first of them with a start flag. Input and output both use valid/ready handshaking. While payload is flowing, the input is passed straight through to the output with no storage in between.

One input selects between two image kinds.

- **Uncompressed images.** The block first walks a header of length-prefixed fields that begins at a fixed offset. It then hunts for a run of four 0xFF bytes. That run is part of the payload, so it is forwarded.
- **Compressed images.** The hunt starts at the first byte and looks for a two-byte marker. The marker is dropped, and the payload begins right after it.

The image length arrives on an input, so back-to-back images are split without any framing signal. When an image ends without its pattern, the block raises a one-cycle miss flag and forwards nothing from that image.

Top module: `cfg_sync_finder`

## Requirements
- R1: In uncompressed mode (cmp_mode=0), the byte at offset 15 of the image is the first header length L. Four fields are walked, and each next field starts L+3 bytes after the current length byte. The pattern hunt starts at the byte after the fourth field, and nothing is forwarded before that point.
- R2: After reset, in_ready=1, out_valid=0 and miss=0. While the block is hunting for the pattern, out_valid stays 0 and in_ready stays 1.
- R3: In uncompressed mode, the payload starts at the first of the first four consecutive 0xFF bytes seen during the hunt. Those four bytes and every following byte up to the end of the image are forwarded in order.
- R4: 0xFF bytes inside the skipped header never count towards the pattern. A run of fewer than four 0xFF bytes followed by any other byte restarts the hunt.
- R5: In compressed mode (cmp_mode=1), the hunt starts at offset 0. The marker is 0xFF followed by a byte whose upper nibble is 0x3; a 0xFF in front of any other upper nibble is not a marker, and a run of several 0xFF bytes followed by 0x3x is. The marker is not forwarded, and the payload is every byte after it up to the end of the image.
- R6: out_start is 1 on exactly one forwarded byte per image that has a non-empty payload, and that byte is the first one.
- R7: If the last byte of an image is accepted while the pattern has still not been found, miss is 1 for exactly the next cycle and no byte of that image is forwarded.
- R8: An image ends after img_len accepted bytes, and the next accepted byte is offset 0 of a new image.
- R9: While the uncompressed pattern is being sent out, in_ready=0 and out_data=0xFF. While payload is passing through, in_ready follows out_ready.
- R10: In compressed mode, a marker in the last two bytes of the image counts as found. Nothing is forwarded and miss stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_mode | input | 1 | 1 = compressed image, 0 = uncompressed image |
| img_len | input | LEN_W | Image length in bytes, held stable during an image |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Forwarded payload byte |
| out_start | output | 1 | First payload byte of an image |
| miss | output | 1 | One-cycle pulse when an image ends with no pattern |

## Verification
The bench uses the default parameters: header at offset 15, four fields, a four-byte pattern and 16-bit lengths. This lets it sweep every mix of short and longer header fields, filled with 0xFF or other bytes, against several decoy runs and pattern lengths in uncompressed mode. In compressed mode it sweeps all sixteen marker tail values against every decoy kind, marker position and payload length, including markers that close the image. Input gaps and output stalls rotate from image to image, so both the preamble replay and the pass-through path are exercised under back-pressure.

// File: rtl/csf_pkg.sv
package csf_pkg;
  typedef enum logic [1:0] {PH_SEEK, PH_REPLAY, PH_PASS} phase_t;
  typedef enum logic [1:0] {W_LEAD, W_LEN, W_SKIP, W_DONE} walk_t;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] TAIL_NIB  = 4'h3;

  // bytes to drop after a header length byte before the next length byte
  function automatic logic [8:0] field_gap(input logic [7:0] len);
    return {1'b0, len} + 9'd2;
  endfunction

  function automatic logic is_tail(input logic [7:0] b);
    return b[7:4] == TAIL_NIB;
  endfunction
endpackage

// File: rtl/csf_pos_track.sv
module csf_pos_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [LEN_W-1:0] img_len,
  output logic [LEN_W-1:0] pos,
  output logic             at_last
);
  assign at_last = (pos == img_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              pos <= '0;
    else if (acc && at_last) pos <= '0;
    else if (acc)            pos <= pos + LEN_W'(1);
  end
endmodule

// File: rtl/csf_hdr_walk.sv
module csf_hdr_walk import csf_pkg::*; #(
  parameter int HDR_OFS = 15,
  parameter int NFIELDS = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             restart,
  input  logic [LEN_W-1:0] pos,
  input  logic [7:0]       data,
  output logic             hdr_done
);
  localparam int FC_W = (NFIELDS > 1) ? $clog2(NFIELDS) : 1;

  walk_t           st;
  logic [FC_W-1:0] fcnt;
  logic [8:0]      skip;

  assign hdr_done = (st == W_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st   <= W_LEAD;
      fcnt <= '0;
      skip <= '0;
    end else if (acc) begin
      case (st)
        W_LEAD: if (pos == LEN_W'(HDR_OFS - 1)) st <= W_LEN;
        W_LEN: begin
          skip <= field_gap(data);
          st   <= W_SKIP;
        end
        W_SKIP: begin
          if (skip == 9'd1) begin
            if (fcnt == FC_W'(NFIELDS - 1)) st <= W_DONE;
            else begin
              fcnt <= fcnt + FC_W'(1);
              st   <= W_LEN;
            end
          end else skip <= skip - 9'd1;
        end
        default: st <= W_DONE;
      endcase
    end
  end
endmodule

// File: rtl/csf_sync_match.sv
module csf_sync_match import csf_pkg::*; #(
  parameter int PRE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_mode,
  input  logic       scan_acc,
  input  logic       restart,
  input  logic [7:0] data,
  output logic       hit
);
  localparam int RUN_W = $clog2(PRE_LEN);

  logic [RUN_W-1:0] run;      // pending 0xFF bytes of a partial uncompressed match
  logic             prev_ff;  // last scanned byte was 0xFF (compressed marker head)
  logic             is_ff;

  assign is_ff = (data == SYNC_BYTE);
  assign hit   = cmp_mode ? (prev_ff && is_tail(data))
                          : (is_ff && run == RUN_W'(PRE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      run     <= '0;
      prev_ff <= 1'b0;
    end else if (scan_acc) begin
      prev_ff <= is_ff;
      if (!is_ff)                           run <= '0;
      else if (run != RUN_W'(PRE_LEN - 1))  run <= run + RUN_W'(1);
    end
  end
endmodule

// File: rtl/cfg_sync_finder.sv
module cfg_sync_finder import csf_pkg::*; #(
  parameter int HDR_OFS = 15,
  parameter int NFIELDS = 4,
  parameter int PRE_LEN = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_mode,
  input  logic [LEN_W-1:0] img_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_start,
  output logic             miss
);
  localparam int RUN_W = $clog2(PRE_LEN);

  phase_t           ph;
  logic [RUN_W-1:0] rcnt;
  logic             end_pend, first_pend, miss_q;

  // named internal events
  logic             seek_w, replay_w, pass_w;
  logic             acc, acc_last, scan_en, scan_acc, hit, hit_ev, img_last;
  logic [LEN_W-1:0] pos;

  assign seek_w   = (ph == PH_SEEK);
  assign replay_w = (ph == PH_REPLAY);
  assign pass_w   = (ph == PH_PASS);

  assign in_ready  = seek_w || (pass_w && out_ready);
  assign out_valid = replay_w || (pass_w && in_valid);
  assign out_data  = replay_w ? SYNC_BYTE : in_data;
  assign out_start = replay_w ? (rcnt == '0) : (pass_w && first_pend && in_valid);
  assign miss      = miss_q;

  assign acc      = in_valid && in_ready;
  assign acc_last = acc && img_last;
  assign scan_acc = acc && seek_w && scan_en;
  assign hit_ev   = scan_acc && hit;

  logic hdr_done;
  assign scan_en = cmp_mode || hdr_done;

  csf_pos_track #(.LEN_W(LEN_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .acc(acc), .img_len(img_len),
    .pos(pos), .at_last(img_last)
  );

  csf_hdr_walk #(.HDR_OFS(HDR_OFS), .NFIELDS(NFIELDS), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .acc(acc), .restart(acc_last),
    .pos(pos), .data(in_data), .hdr_done(hdr_done)
  );

  csf_sync_match #(.PRE_LEN(PRE_LEN)) u_match (
    .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .scan_acc(scan_acc),
    .restart(acc_last), .data(in_data), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_SEEK;
      rcnt       <= '0;
      end_pend   <= 1'b0;
      first_pend <= 1'b0;
      miss_q     <= 1'b0;
    end else begin
      miss_q <= acc_last && seek_w && !hit_ev;
      case (ph)
        PH_SEEK: if (hit_ev) begin
          if (cmp_mode) begin
            if (!img_last) begin
              ph         <= PH_PASS;
              first_pend <= 1'b1;
            end
          end else begin
            ph       <= PH_REPLAY;
            rcnt     <= '0;
            end_pend <= img_last;
          end
        end
        PH_REPLAY: if (out_ready) begin
          if (rcnt == RUN_W'(PRE_LEN - 1)) ph <= end_pend ? PH_SEEK : PH_PASS;
          else rcnt <= rcnt + RUN_W'(1);
        end
        PH_PASS: begin
          if (out_valid && out_ready) first_pend <= 1'b0;
          if (acc_last) begin
            ph         <= PH_SEEK;
            first_pend <= 1'b0;
          end
        end
        default: ph <= PH_SEEK;
      endcase
    end
  end
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_mode,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_start,
  input logic             miss,
  input logic             scan_en,
  input logic             seek_w,
  input logic             replay_w,
  input logic             acc_last,
  input logic [LEN_W-1:0] pos
);
  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_mode && !scan_en) |-> !out_valid);                                  // R1
  AST_SEEK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seek_w |-> (!out_valid && in_ready));                                     // R2
  AST_REPLAY_FF: assert property (@(posedge clk) disable iff (!rst_n)
    replay_w |-> (out_valid && out_data == 8'hFF && !in_ready));              // R9
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);                                                 // R6
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_w && out_start && !out_ready) |=> out_start);                     // R6
  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $past(acc_last));                                                // R7
  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);                                                          // R7
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last |=> (pos == '0));                                                // R8
endmodule

bind cfg_sync_finder csf_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_start(out_start), .miss(miss), .scan_en(scan_en), .seek_w(seek_w),
  .replay_w(replay_w), .acc_last(acc_last), .pos(pos)
);

// File: tb/cfg_sync_finder_test.sv
module cfg_sync_finder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_mode = 1'b0;
  logic [15:0] img_len = 16'd1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_start, miss;
  logic [7:0]  out_data;

  cfg_sync_finder uut (
    .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .img_len(img_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_start(out_start), .miss(miss)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, stall_sel = 0, img_no = 0;
  logic [7:0] img [0:511];
  logic [7:0] got [0:511];
  int n, gcnt, starts, nf_cnt;
  bit first_ok;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s image %0d actual=%0d expected=%0d", tag, img_no, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    img[n] = b;
    n++;
  endtask

  // reference: index arithmetic over the whole image
  function automatic void ref_find(input bit c, output bit f, output int s);
    int ix;
    bit ok;
    f = 0; s = 0; ix = 15; ok = 1;
    if (c) begin
      for (int i = 0; i + 1 < n; i++)
        if (!f && img[i] == 8'hFF && img[i+1][7:4] == 4'h3) begin f = 1; s = i + 2; end
    end else begin
      for (int k = 0; k < 4; k++)
        if (ok && ix < n) ix += int'(img[ix]) + 3; else ok = 0;
      if (ok)
        for (int i = ix; i + 3 < n; i++)
          if (!f && img[i] == 8'hFF && img[i+1] == 8'hFF && img[i+2] == 8'hFF && img[i+3] == 8'hFF)
            begin f = 1; s = i; end
    end
  endfunction

  // collector: downstream stalls, records payload, starts and misses
  initial forever begin
    @(negedge clk);
    out_ready = !(stall_sel[0] && (cyc % 4 == 3));
    #1;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (out_start) begin
          starts++;
          if (gcnt == 0) first_ok = 1;
          if (!cmp_mode) chk(in_ready == 1'b0, "R9 input held during replay", int'(in_ready), 0);
        end
        if (gcnt < 512) got[gcnt] = out_data;
        gcnt++;
      end
      if (miss) nf_cnt++;
    end
  end

  task automatic run_image(input bit c, input string tag);
    bit f;
    int s, el, mm;
    ref_find(c, f, s);
    el = f ? n - s : 0;
    gcnt = 0; starts = 0; nf_cnt = 0; first_ok = 0;
    stall_sel = img_no;
    @(negedge clk);
    cmp_mode = c;
    img_len  = 16'(n);
    for (int i = 0; i < n; i++) begin
      if (stall_sel[1] && ((i + img_no) % 3 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = img[i];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    chk(gcnt == el, {tag, " R8 payload count"}, gcnt, el);
    mm = -1;
    for (int i = 0; i < el && i < 512; i++)
      if (mm < 0 && got[i] !== img[s+i]) mm = i;
    chk(mm < 0, {tag, " payload byte"}, (mm < 0) ? 0 : int'(got[mm]), (mm < 0) ? 0 : int'(img[s+mm]));
    chk(starts == ((el > 0) ? 1 : 0) && (el == 0 || first_ok), "R6 start flag", starts, (el > 0) ? 1 : 0);
    chk(nf_cnt == (f ? 0 : 1), f ? "R7 R10 no miss when found" : "R7 miss pulse", nf_cnt, f ? 0 : 1);
    img_no++;
  endtask

  task automatic build_unc(input int lm, input int v, input int k, input int cut);
    n = 0;
    for (int i = 0; i < 15; i++) put((i == 7) ? 8'hFF : 8'(8'h20 + i));
    for (int f = 0; f < 4; f++) begin
      int l = lm[f] ? 3 : 0;
      put(8'(l));
      for (int j = 0; j < l + 2; j++) put(f[0] ? 8'hFF : 8'(8'h50 + j));
    end
    if (v == 1) begin put(8'hFF); put(8'hFF); put(8'hFF); put(8'h00); end
    if (v == 2) begin put(8'hFF); put(8'h00); put(8'hFF); put(8'hFF); put(8'h12); end
    for (int j = 0; j < k; j++) put(8'hFF);
    for (int j = 0; j < 5; j++) put(8'(j * 29 + 3));
    if (cut > 0) n = cut;
  endtask

  task automatic build_cmp(input int m, input int d, input int t, input int p);
    n = 0;
    for (int j = 0; j < m; j++) put(8'(8'h10 + j));
    if (d == 1) begin put(8'hFF); put(8'h2A); end
    if (d == 2) begin put(8'hFF); put(8'h45); end
    if (d == 3) put(8'hFF);
    put(8'hFF);
    put(8'(8'h30 | t));
    for (int j = 0; j < p; j++) put(8'(j * 53 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0 && miss == 1'b0, "R2 reset state",
        {in_ready, out_valid, miss}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 idle after reset", {in_ready, out_valid}, 2'b10);

    // uncompressed: header length mixes, decoy runs, 4 or 5 byte runs
    for (int lm = 0; lm < 16; lm++)
      for (int v = 0; v < 3; v++)
        for (int k = 4; k < 6; k++) begin
          build_unc(lm, v, k, 0);
          run_image(1'b0, (v == 0) ? "R1 R3" : "R4 R3");
        end
    // uncompressed, pattern absent or image cut inside header
    for (int lm = 0; lm < 16; lm += 5) begin
      build_unc(lm, 1, 0, 0);
      run_image(1'b0, "R7 R4");
      build_unc(lm, 0, 4, 20);
      run_image(1'b0, "R7 R1");
    end
    // compressed: every tail nibble, decoys, positions, payload lengths
    for (int t = 0; t < 16; t++)
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 4; d++)
          for (int p = 0; p < 3; p += 2) begin
            build_cmp(m, d, t, p);
            run_image(1'b1, (p == 0) ? "R10 R5" : "R5");
          end
    // compressed, no marker: trailing 0xFF head only
    for (int m = 1; m < 5; m++) begin
      n = 0;
      for (int j = 0; j < m; j++) put(8'(8'h40 + j));
      put(8'hFF);
      run_image(1'b1, "R7 R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule